// File: doc/BRIEF.md
# Receive/Transmit FIFO Interrupt Controller for a UART

This block sits between a UART's serial engine and the host. It holds two byte FIFOs and raises the interrupts for both of them. Bytes from the deserializer go into the receive FIFO, and the host reads them out with a read strobe. When enough unread bytes are present to satisfy a configurable trigger level, the block pulses a receive interrupt. The host then reads exactly one batch of that many bytes.

If the trigger is satisfied again before the host has finished the current batch, no interrupt is raised. The event is held in a pending counter instead. When the host reads the last byte of a batch, one held event is released as a new interrupt.

On the transmit side, the host writes bytes and the shift register loads them one at a time. Each load produces a one-cycle transmit interrupt. Occupancy of the receive FIFO and free space in the transmit FIFO are given as plain status counts. The receive input cannot be stalled. `rx_in_ready` only reports that a byte would be accepted, and a byte offered while it is low is discarded and flagged. On the transmit write port, a write presented while `tx_wr_ready` is low is dropped and flagged, not held.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: The trigger code is loaded from `cfg_trig` on a cycle with `cfg_we` high. The trigger size is code+1 bytes for codes 0 to 7. Codes 8 to 15 act as 8 bytes.
- R2: When the receive FIFO holds at least the trigger size beyond the bytes already owed to issued or held interrupts, and no batch is outstanding, `rx_irq` goes high for exactly one cycle. This happens one clock after the occupancy change that met the condition.
- R3: A trigger condition met while a batch is still unread raises no pulse. It increments the pending count.
- R4: The clock edge that accepts the final read of a batch makes `rx_irq` high in the following cycle if any event is pending, and consumes one pending event.
- R5: The pending count never exceeds DEPTH/trigger − 1. Bytes left over that are fewer than the trigger size never raise an interrupt.
- R6: Receive bytes come out in arrival order on `rx_rd_data` while `rx_rd_valid` is high. `rx_in_ready` is low exactly when the FIFO is full. A byte offered then is dropped and sets `rx_ovf`. A read while empty has no effect.
- R7: Transmit bytes leave in write order on `tx_out_data`. A write while `tx_wr_ready` is low is dropped and sets `tx_ovf`.
- R8: `tx_irq` is high for one cycle after each edge where `tx_load` pops a byte. A load while `tx_out_valid` is low gives no pulse.
- R9: `rx_count` equals the receive occupancy, and `tx_free` equals DEPTH minus the transmit occupancy. A write and a load in the same cycle leave `tx_free` unchanged.
- R10: `ovf_clr` clears both overflow flags. A drop in the same cycle wins over the clear.
- R11: The synchronous reset `rst` empties both FIFOs, clears the pending and batch state, both flags and both interrupts, and sets the trigger code to 0 (1 byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load trigger code |
| cfg_trig | input | 4 | Trigger code, size = code+1 (saturating at 8) |
| rx_in_valid | input | 1 | Deserializer byte valid |
| rx_in_ready | output | 1 | Receive FIFO not full |
| rx_in_data | input | DW | Deserializer byte |
| rx_rd | input | 1 | Host read strobe |
| rx_rd_valid | output | 1 | Receive FIFO not empty |
| rx_rd_data | output | DW | Oldest receive byte |
| rx_count | output | CW | Receive occupancy |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_wr_valid | input | 1 | Host transmit write |
| tx_wr_ready | output | 1 | Transmit FIFO not full |
| tx_wr_data | input | DW | Transmit byte |
| tx_load | input | 1 | Shift register load strobe |
| tx_out_valid | output | 1 | Transmit FIFO not empty |
| tx_out_data | output | DW | Oldest transmit byte |
| tx_free | output | CW | Empty transmit bytes |
| tx_irq | output | 1 | Transmit interrupt pulse |
| ovf_clr | input | 1 | Clear both overflow flags |
| rx_ovf | output | 1 | Receive byte dropped |
| tx_ovf | output | 1 | Transmit write dropped |

## Verification
The bench sweeps all eight trigger sizes, filling the receive FIFO without reading and then draining it batch by batch. A design that fires on every satisfied trigger would count too many pulses during the fill. One that loses held events would stop issuing interrupts after the first batch, and one with a wrong bound would fire on the short leftover tail. Exact-cycle checks target the one-clock lag after the trigger is met and the immediate release on the final read of a batch. Further checks cover the saturating codes, drops into full FIFOs with clear-versus-set ordering, loads from an empty transmit FIFO, and a simultaneous write and load.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int TRIG_CODE_W = 4;
  localparam int TRIG_MAX    = 8;

  // size in bytes selected by a trigger code; codes with the top bit set saturate
  function automatic logic [3:0] trig_size(input logic [TRIG_CODE_W-1:0] code);
    return code[3] ? 4'(TRIG_MAX) : ({1'b0, code[2:0]} + 4'd1);
  endfunction
endpackage

// File: rtl/uart_sfifo.sv
module uart_sfifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign count     = cnt;
endmodule

// File: rtl/uart_rx_trig_ctrl.sv
module uart_rx_trig_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [3:0]                  trig,
  input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  input  logic                        pop_ok,
  output logic                        irq,
  output logic [$clog2(DEPTH+1)-1:0]  pend_cnt
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = CW + 4;

  logic          active_q, active_n;
  logic [3:0]    rd_q, rd_n;
  logic [CW-1:0] pend_q, pend_n;
  logic          fire, irq_q;
  logic [SW-1:0] claimed;
  logic          new_evt, batch_done;

  // bytes already promised to the outstanding batch and to held events
  always_comb begin
    claimed = SW'(pend_q) * SW'(trig);
    if (active_q) claimed = claimed + SW'(trig) - SW'(rd_q);
  end

  assign new_evt    = SW'(fifo_count) >= (claimed + SW'(trig));
  assign batch_done = active_q && pop_ok && (rd_q == (trig - 4'd1));

  always_comb begin
    fire     = 1'b0;
    active_n = active_q;
    rd_n     = rd_q;
    pend_n   = pend_q;
    if (!active_q) begin
      if (new_evt) begin
        fire     = 1'b1;
        active_n = 1'b1;
        rd_n     = '0;
      end
    end else if (batch_done) begin
      rd_n = '0;
      if (pend_q != '0) begin
        fire   = 1'b1;
        pend_n = new_evt ? pend_q : pend_q - CW'(1);
      end else if (new_evt) begin
        fire = 1'b1;
      end else begin
        active_n = 1'b0;
      end
    end else begin
      rd_n = rd_q + 4'(pop_ok);
      if (new_evt) pend_n = pend_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= '0;
      pend_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      rd_q     <= rd_n;
      pend_q   <= pend_n;
      irq_q    <= fire;
    end
  end

  assign irq      = irq_q;
  assign pend_cnt = pend_q;
endmodule

// File: rtl/uart_evt_flags.sv
module uart_evt_flags (
  input  logic clk,
  input  logic rst,
  input  logic load_ok,
  input  logic rx_drop,
  input  logic tx_drop,
  input  logic clr,
  output logic tx_irq,
  output logic rx_ovf,
  output logic tx_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq <= 1'b0;
      rx_ovf <= 1'b0;
      tx_ovf <= 1'b0;
    end else begin
      tx_irq <= load_ok;
      rx_ovf <= rx_drop || (rx_ovf && !clr);
      tx_ovf <= tx_drop || (tx_ovf && !clr);
    end
  end
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [TRIG_CODE_W-1:0] cfg_trig,
  input  logic                   rx_in_valid,
  output logic                   rx_in_ready,
  input  logic [DW-1:0]          rx_in_data,
  input  logic                   rx_rd,
  output logic                   rx_rd_valid,
  output logic [DW-1:0]          rx_rd_data,
  output logic [CW-1:0]          rx_count,
  output logic                   rx_irq,
  input  logic                   tx_wr_valid,
  output logic                   tx_wr_ready,
  input  logic [DW-1:0]          tx_wr_data,
  input  logic                   tx_load,
  output logic                   tx_out_valid,
  output logic [DW-1:0]          tx_out_data,
  output logic [CW-1:0]          tx_free,
  output logic                   tx_irq,
  input  logic                   ovf_clr,
  output logic                   rx_ovf,
  output logic                   tx_ovf
);
  logic [TRIG_CODE_W-1:0] trig_code_q;
  logic [3:0]             trig_bytes;
  logic                   rx_full, rx_empty, rx_drop, rx_pop_ok;
  logic                   tx_full, tx_empty, tx_drop, tx_load_ok;
  logic [CW-1:0]          tx_count, rx_pend;

  always_ff @(posedge clk) begin
    if (rst)         trig_code_q <= '0;
    else if (cfg_we) trig_code_q <= cfg_trig;
  end
  assign trig_bytes = trig_size(trig_code_q);

  uart_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst),
    .push(rx_in_valid), .push_data(rx_in_data),
    .pop(rx_rd), .head_data(rx_rd_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  uart_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst),
    .push(tx_wr_valid), .push_data(tx_wr_data),
    .pop(tx_load), .head_data(tx_out_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty), .drop(tx_drop)
  );

  assign rx_in_ready  = !rx_full;
  assign rx_rd_valid  = !rx_empty;
  assign rx_pop_ok    = rx_rd && !rx_empty;
  assign tx_wr_ready  = !tx_full;
  assign tx_out_valid = !tx_empty;
  assign tx_load_ok   = tx_load && !tx_empty;
  assign tx_free      = CW'(DEPTH) - tx_count;

  uart_rx_trig_ctrl #(.DEPTH(DEPTH)) u_rx_trig (
    .clk(clk), .rst(rst), .trig(trig_bytes),
    .fifo_count(rx_count), .pop_ok(rx_pop_ok),
    .irq(rx_irq), .pend_cnt(rx_pend)
  );

  uart_evt_flags u_flags (
    .clk(clk), .rst(rst), .load_ok(tx_load_ok),
    .rx_drop(rx_drop), .tx_drop(tx_drop), .clr(ovf_clr),
    .tx_irq(tx_irq), .rx_ovf(rx_ovf), .tx_ovf(tx_ovf)
  );
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_rd,
  input logic          rx_rd_valid,
  input logic [CW-1:0] rx_count,
  input logic          tx_wr_valid,
  input logic          tx_wr_ready,
  input logic          tx_load,
  input logic          tx_out_valid,
  input logic [CW-1:0] tx_free,
  input logic          tx_irq,
  input logic          ovf_clr,
  input logic          rx_ovf,
  input logic          tx_ovf,
  input logic [CW-1:0] pend,
  input logic [3:0]    trig
);
  // R5
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ((32'(pend) + 1) * 32'(trig)) <= DEPTH);

  // R9
  rx_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(rx_count) <= DEPTH);

  // R9
  tx_free_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(tx_free) <= DEPTH);

  // R9
  rx_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rx_in_valid && rx_in_ready) && !(rx_rd && rx_rd_valid)) |=> $stable(rx_count));

  // R6
  rx_drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && !rx_in_ready) |=> rx_ovf);

  // R7
  tx_drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_wr_valid && !tx_wr_ready) |=> tx_ovf);

  // R8
  tx_irq_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_load && tx_out_valid) |=> tx_irq);

  // R8
  tx_irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_load && tx_out_valid) |=> !tx_irq);

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(rx_in_valid && !rx_in_ready)) |=> !rx_ovf);
endmodule

bind uart_fifo_irq_ctrl uart_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
  .rx_rd(rx_rd), .rx_rd_valid(rx_rd_valid), .rx_count(rx_count),
  .tx_wr_valid(tx_wr_valid), .tx_wr_ready(tx_wr_ready),
  .tx_load(tx_load), .tx_out_valid(tx_out_valid), .tx_free(tx_free),
  .tx_irq(tx_irq), .ovf_clr(ovf_clr), .rx_ovf(rx_ovf), .tx_ovf(tx_ovf),
  .pend(rx_pend), .trig(trig_bytes)
);

// File: tb/uart_fifo_irq_ctrl_tb.sv
module uart_fifo_irq_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 0;
  logic [3:0]    cfg_trig = '0;
  logic          rx_in_valid = 0, rx_in_ready;
  logic [DW-1:0] rx_in_data = '0;
  logic          rx_rd = 0, rx_rd_valid;
  logic [DW-1:0] rx_rd_data;
  logic [CW-1:0] rx_count;
  logic          rx_irq;
  logic          tx_wr_valid = 0, tx_wr_ready;
  logic [DW-1:0] tx_wr_data = '0;
  logic          tx_load = 0, tx_out_valid;
  logic [DW-1:0] tx_out_data;
  logic [CW-1:0] tx_free;
  logic          tx_irq;
  logic          ovf_clr = 0, rx_ovf, tx_ovf;

  uart_fifo_irq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_trig(cfg_trig),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_rd(rx_rd), .rx_rd_valid(rx_rd_valid), .rx_rd_data(rx_rd_data),
    .rx_count(rx_count), .rx_irq(rx_irq),
    .tx_wr_valid(tx_wr_valid), .tx_wr_ready(tx_wr_ready), .tx_wr_data(tx_wr_data),
    .tx_load(tx_load), .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .tx_free(tx_free), .tx_irq(tx_irq),
    .ovf_clr(ovf_clr), .rx_ovf(rx_ovf), .tx_ovf(tx_ovf)
  );

  int checks = 0, failures = 0;
  int irq_cnt = 0, txirq_cnt = 0, cyc = 0;

  // count interrupt cycles one time unit after each edge
  always @(posedge clk) begin
    #1;
    if (rx_irq) irq_cnt++;
    if (tx_irq) txirq_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cfg_we = 0; rx_in_valid = 0; rx_rd = 0; tx_wr_valid = 0; tx_load = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    irq_cnt = 0;
    txirq_cnt = 0;
  endtask

  task automatic set_trig(input logic [3:0] c);
    cfg_we = 1; cfg_trig = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 0;
  endtask

  task automatic rx_pop(input int exp, input string req);
    chk(req, int'(rx_rd_data), exp);
    rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_wr_valid = 1; tx_wr_data = d;
    @(negedge clk);
    tx_wr_valid = 0;
  endtask

  task automatic tx_ld(input int exp);
    chk("R7", int'(tx_out_data), exp);
    tx_load = 1;
    @(negedge clk);
    tx_load = 0;
  endtask

  initial begin
    // R11: reset state, including after traffic
    do_reset();
    rx_push(8'h11); rx_push(8'h22); tx_push(8'h33);
    set_trig(4'd5);
    do_reset();
    chk("R11 rx_count", int'(rx_count), 0);
    chk("R11 tx_free", int'(tx_free), DEPTH);
    chk("R11 rx_rd_valid", int'(rx_rd_valid), 0);
    chk("R11 tx_out_valid", int'(tx_out_valid), 0);
    chk("R11 irqs", int'(rx_irq) + int'(tx_irq), 0);
    chk("R11 ovf", int'(rx_ovf) + int'(tx_ovf), 0);
    chk("R11 rx_in_ready", int'(rx_in_ready), 1);
    rx_push(8'h44);
    idle(2);
    chk("R11 default trigger 1 byte", irq_cnt, 1);

    // R2: exact timing with a 2-byte trigger
    do_reset();
    set_trig(4'd1);
    rx_push(8'h01);
    idle(2);
    chk("R2 no pulse below trigger", irq_cnt, 0);
    rx_push(8'h02);
    chk("R2 pulse not yet", int'(rx_irq), 0);
    @(negedge clk);
    chk("R2 pulse one clock later", int'(rx_irq), 1);
    @(negedge clk);
    chk("R2 single cycle", int'(rx_irq), 0);

    // R1: saturating codes act as 8 bytes
    foreach (cfg_trig[k]) begin
      do_reset();
      set_trig(4'(8 + 2 * k));
      for (int i = 0; i < 7; i++) rx_push(8'(i));
      idle(3);
      chk("R1 saturated code below 8", irq_cnt, 0);
      rx_push(8'h07);
      idle(2);
      chk("R1 saturated code at 8", irq_cnt, 1);
    end

    // R3 R4 R5 R6: sweep over every trigger size
    for (int c = 0; c < 8; c++) begin
      int t, nb;
      t  = c + 1;
      nb = DEPTH / t;
      do_reset();
      set_trig(4'(c));
      for (int i = 0; i < DEPTH; i++) rx_push(8'(c * 16 + i));
      idle(3);
      chk("R3 one pulse while batch unread", irq_cnt, 1);
      chk("R9 rx_count full", int'(rx_count), DEPTH);
      chk("R6 ready low when full", int'(rx_in_ready), 0);
      for (int b = 0; b < nb; b++) begin
        for (int j = 0; j < t; j++) rx_pop(c * 16 + b * t + j, "R6 order");
        chk("R4 release on final read", int'(rx_irq), (b < nb - 1) ? 1 : 0);
        idle(2);
        chk("R5 interrupt total", irq_cnt, (b < nb - 1) ? b + 2 : nb);
      end
      for (int j = nb * t; j < DEPTH; j++) rx_pop(c * 16 + j, "R6 order tail");
      idle(3);
      chk("R5 no pulse for short tail", irq_cnt, nb);
      chk("R6 empty after drain", int'(rx_rd_valid), 0);
    end

    // R6 R10: receive overflow, clear, set-over-clear
    do_reset();
    for (int i = 0; i < DEPTH; i++) rx_push(8'(i));
    chk("R6 no ovf yet", int'(rx_ovf), 0);
    rx_push(8'hEE);
    chk("R6 ovf set", int'(rx_ovf), 1);
    chk("R6 count held", int'(rx_count), DEPTH);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    chk("R10 clear", int'(rx_ovf), 0);
    ovf_clr = 1; rx_in_valid = 1; rx_in_data = 8'hEF;
    @(negedge clk);
    ovf_clr = 0; rx_in_valid = 0;
    chk("R10 drop beats clear", int'(rx_ovf), 1);
    for (int i = 0; i < DEPTH; i++) rx_pop(i, "R6 dropped byte absent");
    chk("R6 nothing after drops", int'(rx_rd_valid), 0);
    rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
    chk("R6 read on empty", int'(rx_count), 0);

    // R7 R8 R9: transmit path
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R9 tx_free fill", int'(tx_free), DEPTH - i);
      tx_push(8'(8'hA0 + i));
    end
    chk("R9 tx_free zero", int'(tx_free), 0);
    chk("R7 ready low when full", int'(tx_wr_ready), 0);
    tx_push(8'h55);
    chk("R7 tx ovf", int'(tx_ovf), 1);
    chk("R7 free unchanged", int'(tx_free), 0);
    for (int i = 0; i < DEPTH; i++) begin
      tx_ld(8'hA0 + i);
      chk("R8 pulse after load", int'(tx_irq), 1);
      chk("R9 tx_free drain", int'(tx_free), i + 1);
    end
    chk("R7 empty", int'(tx_out_valid), 0);
    tx_load = 1;
    @(negedge clk);
    tx_load = 0;
    chk("R8 no pulse on empty load", int'(tx_irq), 0);
    idle(2);
    chk("R8 pulse total", txirq_cnt, DEPTH);
    tx_push(8'h61);
    tx_wr_valid = 1; tx_wr_data = 8'h62; tx_load = 1;
    @(negedge clk);
    tx_wr_valid = 0; tx_load = 0;
    chk("R9 write and load together", int'(tx_free), DEPTH - 1);
    chk("R7 order after overlap", int'(tx_out_data), 8'h62);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule